// File: doc/BRIEF.md
# Write Guard and Status Byte Unit

This unit sits between the command decoder of a small serial-programmed memory and its storage array. It keeps the write-permission latch, a two-bit protection level and a stored bit that arms the external write-protect pin. From these it builds the status byte that the host reads back, and it decides for every write request whether the request goes ahead. A granted write starts a busy window of `WR_CYCLES` clocks, which stands in for the programming time.

The decoder raises at most one single-cycle request per cycle. The requests are: set latch, clear latch, status write with a data byte, and array write with a 13-bit address covering 8 KiB. One cycle later the unit answers a status or array write with a grant pulse or a deny pulse. A grant of a status write changes the stored protection fields at once. Those fields show on the status byte after the busy window ends.

Top module: `wp_status_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, busy is low and no grant or deny pulse is raised.
- R2: A set-latch request sets the permission latch and a clear-latch request clears it, whatever the pin level. Clear wins over set, set wins over a status write, and a status write wins over an array write when they coincide.
- R3: When not busy, the status byte reads {arm, 0, 0, 0, lvl[1], lvl[0], latch, 0}, with bit 7 as the most significant bit.
- R4: Each grant makes busy high for exactly `WR_CYCLES` clocks. The status byte reads 0xFF throughout that time.
- R5: A status or array write that arrives while the latch is clear is denied.
- R6: An array write is denied when its address lies in the protected zone. For lvl 00 no address is protected. For 01 the zone is 0x1800-0x1FFF, for 10 it is 0x1000-0x1FFF, and for 11 it is every address.
- R7: A status write is denied while the pin is low and arm is 1. It is allowed (given the latch) when the pin is high or arm is 0.
- R8: A granted status write copies data bits 7, 3 and 2 into arm, lvl[1] and lvl[0]. The other data bits have no effect on the status byte.
- R9: The latch clears in the cycle the busy window ends, and also at the same edge that issues a deny.
- R10: Every request, including set and clear of the latch, is ignored while busy: no pulse, no state change.
- R11: A grant or deny is a single-cycle pulse on the clock edge that follows the request. At most one of the four pulses is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set_i | input | 1 | Set-latch request pulse |
| wel_clr_i | input | 1 | Clear-latch request pulse |
| sr_wr_req_i | input | 1 | Status write request pulse |
| sr_wr_data_i | input | 8 | Status write data byte |
| arr_wr_req_i | input | 1 | Array write request pulse |
| arr_wr_addr_i | input | 13 | Array write byte address |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Readable status byte |
| busy_o | output | 1 | Write cycle in progress |
| arr_grant_o | output | 1 | Array write accepted |
| arr_deny_o | output | 1 | Array write refused |
| sr_grant_o | output | 1 | Status write accepted |
| sr_deny_o | output | 1 | Status write refused |

## Verification
The assertions take the decoder's request pulses as valid inputs. They rely on the status byte, sampled in the cycle of a request, showing the true latch and arm values, which holds because requests only take effect when not busy. The pin is sampled in the same cycle as a status write. Random stimulus lets requests collide, since the priority order is part of the requirements, and it issues many requests inside busy windows so that R10 is exercised. The reference model in the bench steps once per clock with the same priority, so any input pattern stays within what it predicts.

// File: rtl/wpsc_pkg.sv
package wpsc_pkg;

    typedef struct packed {
        logic       wel;
        logic [1:0] lvl;
        logic       arm;
        logic       arr_gnt;
        logic       arr_dny;
        logic       sr_gnt;
        logic       sr_dny;
    } guard_state_t;

    localparam logic [7:0] BUSY_BYTE = 8'hFF;

endpackage

// File: rtl/wpsc_zone_decode.sv
module wpsc_zone_decode #(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        lvl_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    logic top_quarter;
    logic top_half;

    always_comb begin
        top_quarter = (addr_i[TOP -: 2] == 2'b11);
        top_half    = addr_i[TOP];
        unique case (lvl_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = top_quarter;
            2'b10:   hit_o = top_half;
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpsc_busy_timer.sv
module wpsc_busy_timer #(
    parameter int WR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl #(
    parameter int WR_CYCLES = 8,
    parameter int ADDR_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              sr_wr_req_i,
    input  logic [7:0]        sr_wr_data_i,
    input  logic              arr_wr_req_i,
    input  logic [ADDR_W-1:0] arr_wr_addr_i,
    input  logic              wp_n_i,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              arr_grant_o,
    output logic              arr_deny_o,
    output logic              sr_grant_o,
    output logic              sr_deny_o
);
    import wpsc_pkg::*;

    guard_state_t st_d, st_q;
    logic zone_hit;
    logic busy;
    logic last;
    logic start;
    logic hw_lock;

    wpsc_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
        .addr_i (arr_wr_addr_i),
        .lvl_i  (st_q.lvl),
        .hit_o  (zone_hit)
    );

    wpsc_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .last_o  (last)
    );

    assign hw_lock = !wp_n_i && st_q.arm;

    always_comb begin
        st_d         = st_q;
        st_d.arr_gnt = 1'b0;
        st_d.arr_dny = 1'b0;
        st_d.sr_gnt  = 1'b0;
        st_d.sr_dny  = 1'b0;
        start        = 1'b0;
        if (busy) begin
            if (last) st_d.wel = 1'b0;
        end else if (wel_clr_i) begin
            st_d.wel = 1'b0;
        end else if (wel_set_i) begin
            st_d.wel = 1'b1;
        end else if (sr_wr_req_i) begin
            if (st_q.wel && !hw_lock) begin
                st_d.arm    = sr_wr_data_i[7];
                st_d.lvl    = sr_wr_data_i[3:2];
                st_d.sr_gnt = 1'b1;
                start       = 1'b1;
            end else begin
                st_d.sr_dny = 1'b1;
                st_d.wel    = 1'b0;
            end
        end else if (arr_wr_req_i) begin
            if (st_q.wel && !zone_hit) begin
                st_d.arr_gnt = 1'b1;
                start        = 1'b1;
            end else begin
                st_d.arr_dny = 1'b1;
                st_d.wel     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o      = busy;
    assign status_o    = busy ? BUSY_BYTE
                              : {st_q.arm, 3'b000, st_q.lvl, st_q.wel, 1'b0};
    assign arr_grant_o = st_q.arr_gnt;
    assign arr_deny_o  = st_q.arr_dny;
    assign sr_grant_o  = st_q.sr_gnt;
    assign sr_deny_o   = st_q.sr_dny;
endmodule

// File: rtl/wpsc_checker.sv
module wpsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n_i,
    input logic       arr_wr_req_i,
    input logic       sr_wr_req_i,
    input logic [7:0] status_o,
    input logic       busy_o,
    input logic       arr_grant_o,
    input logic       arr_deny_o,
    input logic       sr_grant_o,
    input logic       sr_deny_o
);
    assert_busy_all_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> status_o == 8'hFF);

    assert_idle_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (status_o[6:4] == 3'b000 && !status_o[0]));

    assert_grant_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant_o || sr_grant_o) |-> $past(status_o[1]));

    assert_full_zone_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant_o |-> $past(status_o[3:2]) != 2'b11);

    assert_pin_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant_o |-> !(!$past(wp_n_i) && $past(status_o[7])));

    assert_deny_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_deny_o || sr_deny_o) |-> !status_o[1]);

    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !status_o[1]);

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (arr_wr_req_i || sr_wr_req_i)) |=>
            !(arr_grant_o || arr_deny_o || sr_grant_o || sr_deny_o));

    assert_grant_starts_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant_o || sr_grant_o) |-> busy_o);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_grant_o, arr_deny_o, sr_grant_o, sr_deny_o}));
endmodule

bind wp_status_ctrl wpsc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_n_i       (wp_n_i),
    .arr_wr_req_i (arr_wr_req_i),
    .sr_wr_req_i  (sr_wr_req_i),
    .status_o     (status_o),
    .busy_o       (busy_o),
    .arr_grant_o  (arr_grant_o),
    .arr_deny_o   (arr_deny_o),
    .sr_grant_o   (sr_grant_o),
    .sr_deny_o    (sr_deny_o)
);

// File: tb/wp_status_ctrl_tb.sv
module wp_status_ctrl_tb;
    localparam int NCYC = 8;
    localparam int OP_NONE = 0, OP_SET = 1, OP_CLR = 2, OP_SR = 3, OP_ARR = 4, OP_BOTH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wel_set_i = 1'b0, wel_clr_i = 1'b0;
    logic        sr_wr_req_i = 1'b0, arr_wr_req_i = 1'b0;
    logic [7:0]  sr_wr_data_i = '0;
    logic [12:0] arr_wr_addr_i = '0;
    logic        wp_n_i = 1'b1;
    logic [7:0]  status_o;
    logic        busy_o, arr_grant_o, arr_deny_o, sr_grant_o, sr_deny_o;

    int total = 0;
    int bad = 0;

    logic       m_wel = 0, m_arm = 0;
    logic [1:0] m_lvl = 0;
    int         m_cnt = 0;
    logic       e_ag, e_ad, e_sg, e_sd;

    always #2 clk = ~clk;

    wp_status_ctrl #(.WR_CYCLES(NCYC), .ADDR_W(13)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
        .sr_wr_req_i(sr_wr_req_i), .sr_wr_data_i(sr_wr_data_i),
        .arr_wr_req_i(arr_wr_req_i), .arr_wr_addr_i(arr_wr_addr_i),
        .wp_n_i(wp_n_i), .status_o(status_o), .busy_o(busy_o),
        .arr_grant_o(arr_grant_o), .arr_deny_o(arr_deny_o),
        .sr_grant_o(sr_grant_o), .sr_deny_o(sr_deny_o)
    );

    function automatic logic zone(input logic [1:0] lvl, input logic [12:0] a);
        case (lvl)
            2'd0:    return 1'b0;
            2'd1:    return a >= 13'h1800;
            2'd2:    return a >= 13'h1000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        if (m_cnt != 0) return 8'hFF;
        return {m_arm, 3'b000, m_lvl, m_wel, 1'b0};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input int op, input logic [7:0] d, input logic [12:0] a, input logic wpn);
        e_ag = 0; e_ad = 0; e_sg = 0; e_sd = 0;
        if (m_cnt != 0) begin
            m_cnt--;
            if (m_cnt == 0) m_wel = 0;
        end else if (op == OP_CLR) m_wel = 0;
        else if (op == OP_SET) m_wel = 1;
        else if (op == OP_SR || op == OP_BOTH) begin
            if (m_wel && !(!wpn && m_arm)) begin
                m_arm = d[7]; m_lvl = d[3:2]; e_sg = 1; m_cnt = NCYC;
            end else begin
                e_sd = 1; m_wel = 0;
            end
        end else if (op == OP_ARR) begin
            if (m_wel && !zone(m_lvl, a)) begin
                e_ag = 1; m_cnt = NCYC;
            end else begin
                e_ad = 1; m_wel = 0;
            end
        end
    endtask

    task automatic cyc(input int op, input logic [7:0] d, input logic [12:0] a,
                       input logic wpn, input string tag);
        wel_set_i     = (op == OP_SET);
        wel_clr_i     = (op == OP_CLR);
        sr_wr_req_i   = (op == OP_SR) || (op == OP_BOTH);
        arr_wr_req_i  = (op == OP_ARR) || (op == OP_BOTH);
        sr_wr_data_i  = d;
        arr_wr_addr_i = a;
        wp_n_i        = wpn;
        @(posedge clk);
        model_step(op, d, a, wpn);
        @(negedge clk);
        wel_set_i = 0; wel_clr_i = 0; sr_wr_req_i = 0; arr_wr_req_i = 0;
        check(m_cnt != 0 ? "R4" : "R3", "status", status_o, exp_status());
        check(m_cnt != 0 ? "R4" : "R3", "busy", busy_o, m_cnt != 0);
        check(tag, "arr_grant", arr_grant_o, e_ag);
        check(tag, "arr_deny", arr_deny_o, e_ad);
        check(tag, "sr_grant", sr_grant_o, e_sg);
        check(tag, "sr_deny", sr_deny_o, e_sd);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < NCYC + 1; i++) cyc(OP_NONE, 8'h00, 13'h0, 1'b1, tag);
    endtask

    task automatic set_level(input logic [7:0] d);
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R2");
        cyc(OP_SR, d, 13'h0, 1'b1, "R8");
        drain("R9");
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1", "status", status_o, 8'h00);
        check("R1", "pulses", {arr_grant_o, arr_deny_o, sr_grant_o, sr_deny_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: writes without the latch are denied
        cyc(OP_ARR, 8'h00, 13'h0000, 1'b1, "R5");
        cyc(OP_SR, 8'h8C, 13'h0000, 1'b1, "R5");
        // R2: set, then clear with pin low; clear beats set
        cyc(OP_SET, 8'h00, 13'h0, 1'b0, "R2");
        cyc(OP_CLR, 8'h00, 13'h0, 1'b0, "R2");
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R2");
        // R11: status write beats array write in the same cycle
        cyc(OP_BOTH, 8'h7B, 13'h1FFF, 1'b1, "R11");
        // R10: requests ignored while busy
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R10");
        cyc(OP_ARR, 8'h00, 13'h0000, 1'b1, "R10");
        drain("R9");
        // R8: bits other than 7,3,2 discarded (7B -> lvl 10)
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R2");
        cyc(OP_ARR, 8'h00, 13'h0FFF, 1'b1, "R6");
        drain("R9");
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R2");
        cyc(OP_ARR, 8'h00, 13'h1000, 1'b1, "R6");
        // R6: quarter level edges
        set_level(8'h04);
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R2");
        cyc(OP_ARR, 8'h00, 13'h17FF, 1'b1, "R6");
        drain("R9");
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R2");
        cyc(OP_ARR, 8'h00, 13'h1800, 1'b1, "R6");
        // R6: full level
        set_level(8'h0C);
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R2");
        cyc(OP_ARR, 8'h00, 13'h0000, 1'b1, "R6");
        // R7: arm set, pin low refuses, pin high allows
        set_level(8'h80);
        cyc(OP_SET, 8'h00, 13'h0, 1'b0, "R2");
        cyc(OP_SR, 8'h00, 13'h0, 1'b0, "R7");
        cyc(OP_SET, 8'h00, 13'h0, 1'b1, "R2");
        cyc(OP_SR, 8'h00, 13'h0, 1'b1, "R7");
        drain("R9");
        // random mix, R10 covers ignored requests inside busy windows
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 11;
            int op;
            if (r < 3) op = OP_SET;
            else if (r == 3) op = OP_CLR;
            else if (r < 6) op = OP_SR;
            else if (r < 9) op = OP_ARR;
            else if (r == 9) op = OP_BOTH;
            else op = OP_NONE;
            cyc(op, 8'($urandom), 13'($urandom), 1'($urandom), "R10");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule